// File: doc/BRIEF.md
# Endian-Aware Word Load/Store Lane Unit

This block handles 32-bit word loads and stores between a 64-bit-capable core and a memory bus whose data path is one 64-bit doubleword wide. For each request it receives the virtual address, the translated physical address, the direction, the store data and two endianness controls. One control selects big-endian operation of the core. The other toggles the doubleword half that is addressed in memory.

The unit checks word alignment on the virtual address. A misaligned access never reaches memory. Instead it raises a load fault or a store fault in the same cycle as the request. An aligned access is forwarded to memory with the physical address adjusted by the reverse-endian control.

On a store, the word is placed in the selected 32-bit half of the doubleword, and a byte-enable mask covers only that half. On a load, the word is extracted from the returned doubleword and sign-extended to 64 bits. Address translation, caching and the storage itself sit outside the block.

Top module: `wordlane_unit`

## Requirements
- R1: A request whose virtual address has bit 1 or bit 0 set raises `fault_load` (load) or `fault_store` (store) in the same cycle. It raises `mem_valid` low and `req_ready` high, and it leaves memory contents unchanged.
- R2: `mem_addr` equals `req_paddr` with bit 2 inverted when `cfg_reverse_endian` is 1. All other bits pass through unchanged.
- R3: The byte lane is `req_vaddr[2:0]` with bit 2 inverted when `cfg_big_endian` is 1. For aligned words this gives lane 0 (low half, bits 31:0) or lane 4 (high half, bits 63:32).
- R4: On a store, `mem_wdata` holds `req_wdata` shifted left by 8 times the lane, and the other half reads as zero. `mem_write` is 1 and `mem_size` carries the word access code 2'b10.
- R5: On a store, `mem_be` has four ones starting at the lane: 8'h0F for lane 0 and 8'hF0 for lane 4.
- R6: On a load, `rsp_valid` pulses one cycle after memory accepts the request. At the same time, `rsp_data` is `mem_rdata` shifted right by 8 times the lane, cut to 32 bits and sign-extended to 64 bits.
- R7: A faulting load gives a `rsp_valid` pulse on the following cycle with `rsp_data` equal to zero.
- R8: `mem_valid` is high only for a valid, aligned request. For such a request `req_ready` follows `mem_ready`. Stores produce no `rsp_valid` pulse.
- R9: While `rst_n` is low and after its release, `rsp_valid` stays low until a load is accepted or faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 64 | Virtual address |
| req_paddr | input | 64 | Translated physical address |
| req_wdata | input | 32 | Store word |
| cfg_big_endian | input | 1 | Core big-endian mode |
| cfg_reverse_endian | input | 1 | Toggle of the doubleword half in the physical address |
| fault_load | output | 1 | Misaligned load fault |
| fault_store | output | 1 | Misaligned store fault |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory request is a write |
| mem_size | output | 2 | Access length code (2'b10 = word) |
| mem_addr | output | 64 | Adjusted physical address |
| mem_wdata | output | 64 | Store doubleword |
| mem_be | output | 8 | Store byte enables |
| mem_rdata | input | 64 | Read doubleword, valid the cycle after a load is accepted |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 64 | Sign-extended load result |

## Verification
A wrong lane or a wrong half shows at the ports in the same cycle as the request. It appears as a swapped byte-enable mask, as store data in the wrong half, or as address bit 2 flipped. A stored word read back with the same settings would then come from the other half.

The load side holds state for one cycle: the pending flag, the lane and the zero flag. A corrupted value there shows on the very next cycle as a missing or extra response pulse, a result taken from the wrong half, wrong sign bits, or a nonzero result after a fault. Read-back through the bench memory also shows that a faulting store left the doubleword untouched.

// File: rtl/wl_pkg.sv
// Shared types for the word lane unit.
// Assumes: the memory bus uses a two-bit access-length code.
package wl_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'b00,
        ACC_HALF  = 2'b01,
        ACC_WORD  = 2'b10,
        ACC_DWORD = 2'b11
    } acc_len_e;
endpackage

// File: rtl/wl_align_check.sv
// Word alignment checker.
// Flags a request whose virtual address is not a multiple of the word size,
// and splits the flag into a load fault and a store fault.
// Assumes: WORD_BYTES is a power of two.
module wl_align_check #(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              misaligned,
    output logic              fault_load,
    output logic              fault_store
);
    localparam int OFS_W = $clog2(WORD_BYTES);

    // Decode misalignment and the direction-specific fault.
    always_comb begin
        misaligned  = req_valid && (req_vaddr[OFS_W-1:0] != '0);
        fault_load  = misaligned && !req_is_store;
        fault_store = misaligned && req_is_store;
    end
endmodule

// File: rtl/wl_lane_map.sv
// Endianness mapping.
// The reverse-endian control toggles the half-select bit of the physical
// address. The big-endian control toggles the half-select bit of the byte lane.
// Assumes: DATA_W is a power-of-two multiple of 8 and holds two words.
module wl_lane_map #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              cfg_big_endian,
    input  logic              cfg_reverse_endian,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_paddr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [$clog2(DATA_W/8)-1:0] lane
);
    localparam int LANE_W = $clog2(DATA_W/8);

    // Invert the half-select bit of the address and of the lane.
    always_comb begin
        mem_addr = req_paddr;
        mem_addr[LANE_W-1] = req_paddr[LANE_W-1] ^ cfg_reverse_endian;
        lane = req_vaddr[LANE_W-1:0];
        lane[LANE_W-1] = req_vaddr[LANE_W-1] ^ cfg_big_endian;
    end
endmodule

// File: rtl/wl_store_pack.sv
// Store packer.
// Places the store word at the byte lane of the doubleword and builds the
// matching byte-enable mask.
// Assumes: the lane plus the word size never runs past the doubleword.
module wl_store_pack #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]           wdata,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic [DATA_W/8-1:0]         mem_be
);
    localparam int BYTES      = DATA_W / 8;
    localparam int LANE_W     = $clog2(BYTES);
    localparam int WORD_BYTES = WORD_W / 8;

    logic [LANE_W+2:0] bit_shift;

    // Turn the byte lane into a bit shift and move the word into place.
    always_comb begin
        bit_shift = {lane, 3'b000};
        mem_wdata = DATA_W'(wdata) << bit_shift;
    end

    // Enable each byte that falls inside the word window.
    for (genvar b = 0; b < BYTES; b++) begin : g_be
        always_comb begin
            mem_be[b] = (b >= int'(lane)) && (b < int'(lane) + WORD_BYTES);
        end
    end
endmodule

// File: rtl/wl_load_unpack.sv
// Load unpacker.
// Records the lane of an accepted load and whether a fault forces a zero
// result. One cycle later it extracts the word from the read data,
// sign-extends it and pulses rsp_valid.
// Assumes: mem_rdata is valid in the cycle after the load is accepted.
module wl_load_unpack #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept_load,
    input  logic                        fault_load,
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_data
);
    localparam int LANE_W = $clog2(DATA_W/8);

    logic              pend_valid;
    logic              pend_zero;
    logic [LANE_W-1:0] pend_lane;
    logic [DATA_W-1:0] shifted;
    logic [WORD_W-1:0] word;

    // Capture a pending response for an accepted or faulting load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_zero  <= 1'b0;
            pend_lane  <= '0;
        end else begin
            pend_valid <= accept_load || fault_load;
            pend_zero  <= fault_load;
            pend_lane  <= lane;
        end
    end

    // Extract, sign-extend, or return zero after a fault.
    always_comb begin
        shifted   = mem_rdata >> {pend_lane, 3'b000};
        word      = shifted[WORD_W-1:0];
        rsp_valid = pend_valid;
        rsp_data  = pend_zero ? '0 : {{(DATA_W-WORD_W){word[WORD_W-1]}}, word};
    end

    // R6: a response follows every accepted load on the next cycle.
    assert_rsp_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_load |=> rsp_valid);

    // R7: a faulting load answers zero on the next cycle.
    assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_load |=> (rsp_valid && rsp_data == '0));

    // R9: no response appears without a load on the cycle before.
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_load || fault_load) |=> !rsp_valid);
endmodule

// File: rtl/wordlane_unit.sv
// Word load/store lane unit (top).
// Checks word alignment and adjusts the physical address for reverse-endian
// mode. Stores are packed into the doubleword lane with byte enables, and
// load results are extracted and sign-extended.
// Assumes: one outstanding load at a time, with read data valid on the cycle
// after acceptance.
module wordlane_unit #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_paddr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              cfg_big_endian,
    input  logic              cfg_reverse_endian,
    output logic              fault_load,
    output logic              fault_store,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_be,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    import wl_pkg::*;

    localparam int BYTES      = DATA_W / 8;
    localparam int LANE_W     = $clog2(BYTES);
    localparam int WORD_BYTES = WORD_W / 8;

    logic              misaligned;
    logic [LANE_W-1:0] lane;
    logic              accept_load;

    wl_align_check #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_align (
        .req_valid    (req_valid),
        .req_is_store (req_is_store),
        .req_vaddr    (req_vaddr),
        .misaligned   (misaligned),
        .fault_load   (fault_load),
        .fault_store  (fault_store)
    );

    wl_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
        .cfg_big_endian     (cfg_big_endian),
        .cfg_reverse_endian (cfg_reverse_endian),
        .req_vaddr          (req_vaddr),
        .req_paddr          (req_paddr),
        .mem_addr           (mem_addr),
        .lane               (lane)
    );

    wl_store_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_pack (
        .wdata     (req_wdata),
        .lane      (lane),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    wl_load_unpack #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_unpack (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_load (accept_load),
        .fault_load  (fault_load),
        .lane        (lane),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    // Handshake: faulting requests complete at once; aligned ones wait on memory.
    always_comb begin
        mem_valid   = req_valid && !misaligned;
        mem_write   = req_is_store;
        mem_size    = ACC_WORD;
        req_ready   = misaligned ? 1'b1 : mem_ready;
        accept_load = mem_valid && mem_ready && !req_is_store;
    end

    // R1: a misaligned request never reaches memory and always faults.
    assert_no_mem_on_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_vaddr[1:0] != 2'b00) |-> (!mem_valid && (fault_load || fault_store) && req_ready));

    // R2: only the half-select bit of the address may differ from the physical address.
    assert_addr_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_addr ^ req_paddr) == (ADDR_W'(cfg_reverse_endian) << (LANE_W-1))));

    // R5: a store enables exactly one word of bytes.
    assert_be_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> ($countones(mem_be) == WORD_BYTES));

    // R8: an aligned request stalls while memory is not ready.
    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |-> !req_ready);
endmodule

// File: tb/wordlane_unit_tb.sv
module wordlane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_store = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_paddr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_big_endian = 1'b0;
    logic        cfg_reverse_endian = 1'b0;
    logic        fault_load, fault_store;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_write;
    logic [1:0]  mem_size;
    logic [63:0] mem_addr, mem_wdata;
    logic [7:0]  mem_be;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wordlane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_vaddr(req_vaddr), .req_paddr(req_paddr),
        .req_wdata(req_wdata), .cfg_big_endian(cfg_big_endian),
        .cfg_reverse_endian(cfg_reverse_endian), .fault_load(fault_load),
        .fault_store(fault_store), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_write(mem_write), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // Single-cycle memory model: eight doublewords indexed by address bits 5:3.
    logic [63:0] mem_arr [0:7];
    initial for (int i = 0; i < 8; i++) mem_arr[i] = '0;
    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem_arr[mem_addr[5:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem_arr[mem_addr[5:3]];
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        st;
        logic [2:0]  va_lo;
        logic [63:0] pa;
        logic        big;
        logic        rev;
        logic [31:0] wd;
        logic [63:0] e_addr;
        logic [7:0]  e_be;
        logic [63:0] e_data;   // store: mem_wdata; load: rsp_data
    } vec_t;

    localparam vec_t VEC [0:11] = '{
        '{1'b1, 3'd0, 64'h100, 1'b0, 1'b0, 32'h11223344, 64'h100, 8'h0F, 64'h00000000_11223344},
        '{1'b1, 3'd4, 64'h104, 1'b0, 1'b0, 32'hA5A50001, 64'h104, 8'hF0, 64'hA5A50001_00000000},
        '{1'b1, 3'd0, 64'h108, 1'b1, 1'b0, 32'hCAFEBABE, 64'h108, 8'hF0, 64'hCAFEBABE_00000000},
        '{1'b1, 3'd4, 64'h10C, 1'b1, 1'b0, 32'h01020304, 64'h10C, 8'h0F, 64'h00000000_01020304},
        '{1'b1, 3'd0, 64'h110, 1'b0, 1'b1, 32'h55AA55AA, 64'h114, 8'h0F, 64'h00000000_55AA55AA},
        '{1'b1, 3'd4, 64'h11C, 1'b1, 1'b1, 32'h87654321, 64'h118, 8'h0F, 64'h00000000_87654321},
        '{1'b0, 3'd0, 64'h100, 1'b0, 1'b0, 32'h0,        64'h100, 8'h00, 64'h00000000_11223344},
        '{1'b0, 3'd4, 64'h104, 1'b0, 1'b0, 32'h0,        64'h104, 8'h00, 64'hFFFFFFFF_A5A50001},
        '{1'b0, 3'd0, 64'h108, 1'b1, 1'b0, 32'h0,        64'h108, 8'h00, 64'hFFFFFFFF_CAFEBABE},
        '{1'b0, 3'd4, 64'h10C, 1'b1, 1'b0, 32'h0,        64'h10C, 8'h00, 64'h00000000_01020304},
        '{1'b0, 3'd0, 64'h110, 1'b0, 1'b1, 32'h0,        64'h114, 8'h00, 64'h00000000_55AA55AA},
        '{1'b0, 3'd4, 64'h11C, 1'b1, 1'b1, 32'h0,        64'h118, 8'h00, 64'hFFFFFFFF_87654321}
    };

    // Sampled results of the last request.
    logic [63:0] s_addr, s_wdata, s_rsp;
    logic [7:0]  s_be;
    logic [1:0]  s_size;
    logic        s_mv, s_rdy, s_fl, s_fs, s_rv, s_wr;

    // Drive one request at a negedge; sample the request side before the edge
    // and the response side at the following negedge.
    task automatic do_req(input logic st, input logic [63:0] va, input logic [63:0] pa,
                          input logic big, input logic rev, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_is_store = st; req_vaddr = va; req_paddr = pa;
        cfg_big_endian = big; cfg_reverse_endian = rev; req_wdata = wd;
        #1;
        s_addr = mem_addr; s_wdata = mem_wdata; s_be = mem_be; s_size = mem_size;
        s_mv = mem_valid; s_rdy = req_ready; s_fl = fault_load; s_fs = fault_store;
        s_wr = mem_write;
        @(negedge clk);
        s_rv = rsp_valid; s_rsp = rsp_data;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R8 mem_valid idle", 64'(mem_valid), 64'd0);

        // Table walk: stores fill the model, loads read back.
        for (int i = 0; i < 12; i++) begin
            do_req(VEC[i].st, 64'h2000_0000 | 64'(VEC[i].va_lo), VEC[i].pa,
                   VEC[i].big, VEC[i].rev, VEC[i].wd);
            check($sformatf("R2 mem_addr vec %0d", i), s_addr, VEC[i].e_addr);
            check($sformatf("R8 mem_valid vec %0d", i), 64'({s_mv, s_rdy}), 64'd3);
            if (VEC[i].st) begin
                check($sformatf("R3 R4 mem_wdata vec %0d", i), s_wdata, VEC[i].e_data);
                check($sformatf("R5 mem_be vec %0d", i), 64'(s_be), 64'(VEC[i].e_be));
                check($sformatf("R4 write/size vec %0d", i), 64'({s_wr, s_size}), 64'b110);
                check($sformatf("R8 no rsp on store vec %0d", i), 64'(s_rv), 64'd0);
            end else begin
                check($sformatf("R6 rsp_valid vec %0d", i), 64'(s_rv), 64'd1);
                check($sformatf("R6 rsp_data vec %0d", i), s_rsp, VEC[i].e_data);
            end
        end

        // R1/R7: misaligned load faults, no memory request, zero result.
        do_req(1'b0, 64'h2000_0001, 64'h101, 1'b0, 1'b0, 32'h0);
        check("R1 load fault flags", 64'({s_fl, s_fs}), 64'b10);
        check("R1 load no mem_valid, ready", 64'({s_mv, s_rdy}), 64'b01);
        check("R7 fault rsp_valid", 64'(s_rv), 64'd1);
        check("R7 fault rsp_data zero", s_rsp, 64'd0);

        // R1: misaligned store faults and leaves memory untouched.
        do_req(1'b1, 64'h2000_0002, 64'h102, 1'b0, 1'b0, 32'hDEADBEEF);
        check("R1 store fault flags", 64'({s_fl, s_fs}), 64'b01);
        check("R1 store no mem_valid, ready", 64'({s_mv, s_rdy}), 64'b01);
        check("R1 store fault no rsp", 64'(s_rv), 64'd0);
        do_req(1'b0, 64'h2000_0000, 64'h100, 1'b0, 1'b0, 32'h0);
        check("R1 memory unchanged after faulting store", s_rsp, 64'h00000000_11223344);

        // R8: memory stall holds req_ready low; no response while stalled.
        mem_ready = 1'b0;
        do_req(1'b0, 64'h2000_0004, 64'h104, 1'b0, 1'b0, 32'h0);
        check("R8 stalled req_ready low", 64'({s_mv, s_rdy}), 64'b10);
        check("R8 stalled no rsp", 64'(s_rv), 64'd0);
        mem_ready = 1'b1;

        // R9: reset in the middle of a load drops the pending response.
        @(negedge clk);
        req_valid = 1'b1; req_is_store = 1'b0; req_vaddr = 64'h2000_0000;
        req_paddr = 64'h100; cfg_big_endian = 1'b0; cfg_reverse_endian = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 rsp_valid held low in reset", 64'(rsp_valid), 64'd0);
        req_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R9 rsp_valid low after reset", 64'(rsp_valid), 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule